// File: doc/BRIEF.md
# D-PHY High-Speed Burst Entry/Exit Sequencer

This block steps the clock lane and a group of data lanes of a D-PHY transmitter through the low-power and high-speed line states around each transmit burst. It works at byte-clock granularity, where one cycle is eight unit intervals. Each lane's line state comes out as a small code, and each lane's payload comes out as one byte per cycle. The analog drivers and the serializer downstream turn these into wire levels.

A burst starts when `tx_req` is high while the block is idle and ready. The clock lane leaves the stop state first, unless it is already running. The data lanes then leave the stop state, send the sync byte and stream one byte per accepted handshake. They close with a trail and an exit gap. Every interval comes from a 7-bit field plus a fixed offset. A lane-control word can replace all the fields with built-in defaults. The same word also picks the number of active lanes and a continuous-clock mode.

The block raises a ready flag after a programmable wakeup wait. This wait runs after reset and again after each reload request.

Top module: `dphy_hs_seq`

## Requirements
- R1: While reset is held and right after it, every lane shows line code 0 (stop, LP-11), every byte output is 0, and `phy_ready` and `tx_ready` are 0.
- R2: `phy_ready` is low for the first wake+1 cycles after reset, and for wake+1 cycles after a `cfg_reload` pulse taken while idle. While it is low, `tx_req` is ignored and all lanes stay in their idle state.
- R3: Without a running clock, a burst begins on the clock lane with code 1 (LP-01) for ck_lpx+1 cycles, code 2 (LP-00) for ck_prep+1, code 3 (HS-zero) for ck_zero+1, then code 4 (HS). Code 4 holds for max(1, pre−ck_lpx−ck_zero−3) cycles before the data lanes leave the stop state.
- R4: Active data lanes then show code 1 for dat_lpx+1 cycles, code 2 for dat_prep+1 cycles and code 3 for dat_zero+6 cycles.
- R5: The first HS cycle (code 4) of every active data lane carries byte 0xB8. `tx_ready` is high only in that cycle and in the data cycles that follow. Each cycle with both `tx_req` and `tx_ready` high takes one byte per lane from `tx_data` (lane k in bits 8k+7..8k), and that byte appears in the next cycle. A cycle of `tx_ready` with `tx_req` low ends the data phase.
- R6: Data lanes then show code 5 (HS-trail) for dat_trail+2 cycles and return to code 0. In non-continuous mode the clock lane stays at code 4 for post+8 more cycles, then shows code 5 for ck_trail+1 cycles, then code 0. After that, gap+9 stop cycles pass before a new request is taken.
- R7: With `cfg_lane` bit 4 set, the clock lane skips its post and trail phases and stays at code 4 while idle. The next burst then starts directly with the data-lane LP-01 phase.
- R8: `cfg_lane` bits 1..0 hold the active lane count minus one and are captured at burst start. Lanes above that count stay at code 0 with byte 0.
- R9: With `cfg_lane` bit 8 set, the built-in defaults replace the programmed fields: pre 24, post 5, gap 2; clock LPX 3, prepare 2, zero 10, trail 4; data LPX 3, prepare 2, zero 4, trail 3.
- R10: Field positions are as follows. `cfg_ctl` holds pre in bits 6..0, post in 14..8 and gap in 22..16. `cfg_clk` and `cfg_dat` each hold LPX in bits 6..0, prepare in 14..8, zero in 22..16 and trail in 30..24. `cfg_wake` is a 19-bit wakeup count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_req | input | 1 | Burst request; held high while bytes remain |
| tx_data | input | 32 | One byte per lane, lane k in bits 8k+7..8k |
| tx_ready | output | 1 | Byte accepted this cycle when tx_req is high |
| cfg_ctl | input | 32 | pre / post / gap fields |
| cfg_clk | input | 32 | Clock-lane LPX / prepare / zero / trail fields |
| cfg_dat | input | 32 | Data-lane LPX / prepare / zero / trail fields |
| cfg_lane | input | 9 | Lane count minus one, continuous clock (bit 4), default timing (bit 8) |
| cfg_wake | input | 19 | Wakeup wait count |
| cfg_reload | input | 1 | Request a new wakeup wait (taken while idle) |
| phy_ready | output | 1 | Wakeup wait complete |
| clk_line | output | 3 | Clock-lane line state code |
| dat_line | output | 12 | Data-lane line state codes, lane k in bits 3k+2..3k |
| dat_byte | output | 32 | HS payload byte per lane, 0 outside HS data |

## Verification
Bursts run with programmed fields whose offsets give distinct phase lengths, with a pre value small enough to force the one-cycle clock-pre floor, and with the default-timing flag. A timing offset or field-position mistake then shows up as a shifted phase edge. Lane counts of one, two and four separate the active-lane capture from the per-lane byte routing. Back-to-back continuous-clock bursts followed by a non-continuous one show whether the clock lane is kept or released at the right point. Requests raised before ready and after a reload show whether the wakeup wait gates burst start.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;

    localparam int DUR_W  = 8;
    localparam int FLD_W  = 7;
    localparam int WAKE_W = 19;
    localparam logic [7:0] SYNC_BYTE = 8'hB8;

    // Line-state codes seen by the lane drivers
    typedef enum logic [2:0] {
        LS_STOP   = 3'd0,
        LS_REQ    = 3'd1,
        LS_BRIDGE = 3'd2,
        LS_HSZERO = 3'd3,
        LS_HS     = 3'd4,
        LS_TRAIL  = 3'd5
    } line_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CLPX, S_CPREP, S_CZERO, S_CPRE,
        S_DLPX, S_DPREP, S_DZERO, S_SYNC, S_DATA,
        S_DTRAIL, S_CPOST, S_CTRAIL, S_EXIT
    } seq_e;

    typedef struct packed {
        logic [DUR_W-1:0] ck_lpx;
        logic [DUR_W-1:0] ck_prep;
        logic [DUR_W-1:0] ck_zero;
        logic [DUR_W-1:0] ck_pre;
        logic [DUR_W-1:0] ck_post;
        logic [DUR_W-1:0] ck_trail;
        logic [DUR_W-1:0] dt_lpx;
        logic [DUR_W-1:0] dt_prep;
        logic [DUR_W-1:0] dt_zero;
        logic [DUR_W-1:0] dt_trail;
        logic [DUR_W-1:0] hs_exit;
    } dur_t;

    function automatic logic [DUR_W-1:0] add_ofs(input logic [FLD_W-1:0] f, input int unsigned ofs);
        return DUR_W'(f) + DUR_W'(ofs);
    endfunction

endpackage

// File: rtl/dphy_seq_timing.sv
module dphy_seq_timing
    import dphy_seq_pkg::*;
#(
    parameter logic [31:0] DEF_CTL = 32'h0002_0518,
    parameter logic [31:0] DEF_CLK = 32'h040A_0203,
    parameter logic [31:0] DEF_DAT = 32'h0304_0203
) (
    input  logic [31:0] ctl_i,
    input  logic [31:0] clk_i,
    input  logic [31:0] dat_i,
    input  logic        use_def_i,
    output dur_t        dur_o
);

    logic [31:0] ctl_w, clk_w, dat_w;
    int          pre_i;

    // R9: built-in words replace the programmed ones
    always_comb begin
        ctl_w = use_def_i ? DEF_CTL : ctl_i;
        clk_w = use_def_i ? DEF_CLK : clk_i;
        dat_w = use_def_i ? DEF_DAT : dat_i;
    end

    // R10: field k of a word sits at bits 8k+6..8k
    always_comb begin
        dur_o.ck_lpx   = add_ofs(clk_w[6:0],   1);
        dur_o.ck_prep  = add_ofs(clk_w[14:8],  1);
        dur_o.ck_zero  = add_ofs(clk_w[22:16], 1);
        dur_o.ck_trail = add_ofs(clk_w[30:24], 1);
        dur_o.dt_lpx   = add_ofs(dat_w[6:0],   1);
        dur_o.dt_prep  = add_ofs(dat_w[14:8],  1);
        dur_o.dt_zero  = add_ofs(dat_w[22:16], 6);
        dur_o.dt_trail = add_ofs(dat_w[30:24], 2);
        dur_o.ck_post  = add_ofs(ctl_w[14:8],  8);
        dur_o.hs_exit  = add_ofs(ctl_w[22:16], 9);
        // R3: pre is measured from clock LP exit; floor at one cycle
        pre_i = int'(ctl_w[6:0]) - int'(clk_w[6:0]) - int'(clk_w[22:16]) - 3;
        dur_o.ck_pre = (pre_i < 1) ? DUR_W'(1) : DUR_W'(pre_i);
    end

    logic unused_bits;
    assign unused_bits = ^{ctl_w[31:23], ctl_w[15], ctl_w[7],
                           clk_w[31], clk_w[23], clk_w[15], clk_w[7],
                           dat_w[31], dat_w[23], dat_w[15], dat_w[7]};

endmodule

// File: rtl/dphy_seq_ctrl.sv
module dphy_seq_ctrl
    import dphy_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              reload_i,
    input  logic              cont_i,
    input  logic [WAKE_W-1:0] wake_i,
    input  dur_t              dur_i,
    output seq_e              state_o,
    output logic              clk_on_o,
    output logic              ready_o,
    output logic              tx_ready_o,
    output logic              start_o,
    output logic              sync_o,
    output logic              take_o
);

    typedef struct packed {
        seq_e              state;
        logic [DUR_W-1:0]  cnt;
        logic              clk_on;
        logic              ready;
        logic [WAKE_W-1:0] wcnt;
    } ctrl_t;

    ctrl_t q, d;
    logic  done;

    function automatic logic [DUR_W-1:0] dur_of(input seq_e s, input dur_t t);
        case (s)
            S_CLPX:   return t.ck_lpx;
            S_CPREP:  return t.ck_prep;
            S_CZERO:  return t.ck_zero;
            S_CPRE:   return t.ck_pre;
            S_DLPX:   return t.dt_lpx;
            S_DPREP:  return t.dt_prep;
            S_DZERO:  return t.dt_zero;
            S_DTRAIL: return t.dt_trail;
            S_CPOST:  return t.ck_post;
            S_CTRAIL: return t.ck_trail;
            S_EXIT:   return t.hs_exit;
            default:  return DUR_W'(1);
        endcase
    endfunction

    always_comb begin
        d       = q;
        start_o = 1'b0;
        done    = (q.cnt == '0);
        // R2: wakeup wait
        if (!q.ready) begin
            if (q.wcnt == wake_i) d.ready = 1'b1;
            else                  d.wcnt  = q.wcnt + 1'b1;
        end
        unique case (q.state)
            S_IDLE: begin
                if (reload_i) begin
                    d.ready = 1'b0;
                    d.wcnt  = '0;
                end else if (q.ready && req_i) begin
                    start_o = 1'b1;
                    d.state = q.clk_on ? S_DLPX : S_CLPX;
                end
            end
            S_CLPX:  if (done) d.state = S_CPREP;
            S_CPREP: if (done) d.state = S_CZERO;
            S_CZERO: if (done) begin
                d.state  = S_CPRE;
                d.clk_on = 1'b1;
            end
            S_CPRE:  if (done) d.state = S_DLPX;
            S_DLPX:  if (done) d.state = S_DPREP;
            S_DPREP: if (done) d.state = S_DZERO;
            S_DZERO: if (done) d.state = S_SYNC;
            S_SYNC, S_DATA: d.state = req_i ? S_DATA : S_DTRAIL;
            S_DTRAIL: if (done) d.state = cont_i ? S_EXIT : S_CPOST;
            S_CPOST:  if (done) d.state = S_CTRAIL;
            S_CTRAIL: if (done) begin
                d.state  = S_EXIT;
                d.clk_on = 1'b0;
            end
            S_EXIT:  if (done) d.state = S_IDLE;
            default: d.state = S_IDLE;
        endcase
        if (d.state != q.state) d.cnt = dur_of(d.state, dur_i) - 1'b1;
        else if (!done)         d.cnt = q.cnt - 1'b1;
    end

    // R1: reset puts every lane in stop and the ready flag low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state  <= S_IDLE;
            q.cnt    <= '0;
            q.clk_on <= 1'b0;
            q.ready  <= 1'b0;
            q.wcnt   <= '0;
        end else begin
            q <= d;
        end
    end

    assign state_o    = q.state;
    assign clk_on_o   = q.clk_on;
    assign ready_o    = q.ready;
    assign tx_ready_o = (q.state == S_SYNC) || (q.state == S_DATA);
    assign take_o     = tx_ready_o && req_i;
    assign sync_o     = (q.state == S_DZERO) && done;

    AST_IDLE_WHILE_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_IDLE && !q.ready) |=> (q.state == S_IDLE)); // R2

    AST_PHASE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state != $past(q.state)) && !($past(q.state) inside {S_IDLE, S_SYNC, S_DATA}))
        |-> ($past(q.cnt) == '0)); // R3 R4 R6

    AST_CONT_CLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_IDLE && q.clk_on && cont_i) |=> q.clk_on); // R7

    AST_CLOCK_UP_FOR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |-> q.clk_on); // R5

endmodule

// File: rtl/dphy_seq_lanes.sv
module dphy_seq_lanes
    import dphy_seq_pkg::*;
#(
    parameter int LANES = 4,
    localparam int LCW  = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  seq_e               state_i,
    input  logic               clk_on_i,
    input  logic               start_i,
    input  logic               sync_i,
    input  logic               take_i,
    input  logic [LCW-1:0]     lane_sel_i,
    input  logic [LANES*8-1:0] tx_data_i,
    output logic [2:0]         clk_line_o,
    output logic [LANES*3-1:0] dat_line_o,
    output logic [LANES*8-1:0] dat_byte_o
);

    typedef struct packed {
        logic [LANES-1:0]      act;
        logic [LANES-1:0][7:0] bytes;
    } lane_t;

    lane_t q, d;
    line_e dline, cline;
    logic  hs_on;

    always_comb begin
        d = q;
        for (int i = 0; i < LANES; i++) begin
            // R8: active lanes latched when a burst starts
            if (start_i) d.act[i] = (LCW'(i) <= lane_sel_i);
            if (sync_i)      d.bytes[i] = SYNC_BYTE;
            else if (take_i) d.bytes[i] = tx_data_i[i*8 +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.act   <= '0;
            q.bytes <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (state_i)
            S_DLPX:         dline = LS_REQ;
            S_DPREP:        dline = LS_BRIDGE;
            S_DZERO:        dline = LS_HSZERO;
            S_SYNC, S_DATA: dline = LS_HS;
            S_DTRAIL:       dline = LS_TRAIL;
            default:        dline = LS_STOP;
        endcase
        unique case (state_i)
            S_IDLE, S_EXIT: cline = clk_on_i ? LS_HS : LS_STOP;
            S_CLPX:         cline = LS_REQ;
            S_CPREP:        cline = LS_BRIDGE;
            S_CZERO:        cline = LS_HSZERO;
            S_CTRAIL:       cline = LS_TRAIL;
            default:        cline = LS_HS;
        endcase
    end

    assign hs_on      = (state_i == S_SYNC) || (state_i == S_DATA);
    assign clk_line_o = cline;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dat_line_o[g*3 +: 3] = q.act[g] ? dline : LS_STOP;
        assign dat_byte_o[g*8 +: 8] = (q.act[g] && hs_on) ? q.bytes[g] : 8'h00;

        AST_SYNC_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
            (dat_line_o[g*3 +: 3] == LS_HS && $past(dat_line_o[g*3 +: 3]) != LS_HS)
            |-> (dat_byte_o[g*8 +: 8] == SYNC_BYTE)); // R5
    end

    AST_TRAIL_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_line_o == LS_TRAIL && $past(clk_line_o) != LS_TRAIL)
        |-> ($past(clk_line_o) == LS_HS)); // R6

endmodule

// File: rtl/dphy_hs_seq.sv
module dphy_hs_seq
    import dphy_seq_pkg::*;
#(
    parameter int          LANES   = 4,
    parameter logic [31:0] DEF_CTL = 32'h0002_0518,
    parameter logic [31:0] DEF_CLK = 32'h040A_0203,
    parameter logic [31:0] DEF_DAT = 32'h0304_0203
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_req,
    input  logic [LANES*8-1:0] tx_data,
    output logic               tx_ready,
    input  logic [31:0]        cfg_ctl,
    input  logic [31:0]        cfg_clk,
    input  logic [31:0]        cfg_dat,
    input  logic [8:0]         cfg_lane,
    input  logic [18:0]        cfg_wake,
    input  logic               cfg_reload,
    output logic               phy_ready,
    output logic [2:0]         clk_line,
    output logic [LANES*3-1:0] dat_line,
    output logic [LANES*8-1:0] dat_byte
);

    localparam int LCW = $clog2(LANES);

    dur_t dur;
    seq_e state;
    logic clk_on, start, sync, take;

    dphy_seq_timing #(
        .DEF_CTL(DEF_CTL), .DEF_CLK(DEF_CLK), .DEF_DAT(DEF_DAT)
    ) i_timing (
        .ctl_i(cfg_ctl), .clk_i(cfg_clk), .dat_i(cfg_dat),
        .use_def_i(cfg_lane[8]), .dur_o(dur)
    );

    dphy_seq_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(tx_req), .reload_i(cfg_reload),
        .cont_i(cfg_lane[4]), .wake_i(cfg_wake), .dur_i(dur),
        .state_o(state), .clk_on_o(clk_on), .ready_o(phy_ready),
        .tx_ready_o(tx_ready), .start_o(start), .sync_o(sync), .take_o(take)
    );

    dphy_seq_lanes #(.LANES(LANES)) i_lanes (
        .clk(clk), .rst_n(rst_n), .state_i(state), .clk_on_i(clk_on),
        .start_i(start), .sync_i(sync), .take_i(take),
        .lane_sel_i(cfg_lane[LCW-1:0]), .tx_data_i(tx_data),
        .clk_line_o(clk_line), .dat_line_o(dat_line), .dat_byte_o(dat_byte)
    );

    logic unused_lane_bits;
    assign unused_lane_bits = ^{cfg_lane[7:5], cfg_lane[3:LCW]};

endmodule

// File: tb/test_dphy_hs_seq.sv
module test_dphy_hs_seq;

    localparam int CLK_P = 10;
    localparam logic [31:0] D_CTL = 32'h0002_0518;
    localparam logic [31:0] D_CLK = 32'h040A_0203;
    localparam logic [31:0] D_DAT = 32'h0304_0203;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_r = 1'b0;
    logic [31:0] data_r = '0;
    logic [31:0] ctl_w = '0, clk_w = '0, dat_w = '0;
    logic [8:0]  lane_w = 9'h003;
    logic [18:0] wake_w = 19'd4;
    logic        reload_r = 1'b0;
    logic        tx_ready, phy_ready;
    logic [2:0]  clk_line;
    logic [11:0] dat_line;
    logic [31:0] dat_byte;

    dphy_hs_seq i_dphy_hs_seq (
        .clk(clk), .rst_n(rst_n), .tx_req(req_r), .tx_data(data_r), .tx_ready(tx_ready),
        .cfg_ctl(ctl_w), .cfg_clk(clk_w), .cfg_dat(dat_w), .cfg_lane(lane_w),
        .cfg_wake(wake_w), .cfg_reload(reload_r), .phy_ready(phy_ready),
        .clk_line(clk_line), .dat_line(dat_line), .dat_byte(dat_byte)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        logic [2:0]  ck;
        logic [2:0]  dl;
        logic [31:0] by;
        logic        rdy;
        logic [3:0]  act;
        int          tag;
    } ent_t;

    ent_t q[$];
    ent_t e;
    int   nchk = 0, nerr = 0, cyc = 0;
    bit   run = 0, fin = 0, want = 0;
    int   nb = 0, sent = 0, mw = 0;
    bit   mready = 0, mclk_on = 0, was_idle, go;
    logic [3:0] mact = '0;

    function automatic logic [7:0] pat(int i, int l);
        return 8'((i * 37 + l * 11 + 5) & 255);
    endfunction

    task automatic chk(bit ok, int tag, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL R%0d %s at cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
        end
    endtask

    task automatic push(int n, logic [2:0] ck, logic [2:0] dl, logic [31:0] by, logic rdy, int tag);
        for (int k = 0; k < n; k++) q.push_back('{ck, dl, by, rdy, mact, tag});
    endtask

    // Reference sequence for one burst, built from the requirement formulas
    task automatic push_burst();
        logic [31:0] c, k, t;
        int pre, tg;
        logic [31:0] by;
        c = lane_w[8] ? D_CTL : ctl_w;   // R9 defaults
        k = lane_w[8] ? D_CLK : clk_w;
        t = lane_w[8] ? D_DAT : dat_w;
        for (int l = 0; l < 4; l++) mact[l] = (l <= int'(lane_w[1:0]));
        // R10: fields at bits 8n+6..8n
        pre = int'(c[6:0]) - int'(k[6:0]) - int'(k[22:16]) - 3;
        if (pre < 1) pre = 1;
        if (!mclk_on) begin
            tg = lane_w[8] ? 9 : 3;   // R3
            push(int'(k[6:0]) + 1,   3'd1, 3'd0, '0, 1'b0, tg);
            push(int'(k[14:8]) + 1,  3'd2, 3'd0, '0, 1'b0, tg);
            push(int'(k[22:16]) + 1, 3'd3, 3'd0, '0, 1'b0, tg);
            push(pre,                3'd4, 3'd0, '0, 1'b0, tg);
        end
        tg = lane_w[8] ? 9 : 4;       // R4
        push(int'(t[6:0]) + 1,   3'd4, 3'd1, '0, 1'b0, tg);
        push(int'(t[14:8]) + 1,  3'd4, 3'd2, '0, 1'b0, tg);
        push(int'(t[22:16]) + 6, 3'd4, 3'd3, '0, 1'b0, tg);
        for (int l = 0; l < 4; l++) by[l*8 +: 8] = mact[l] ? 8'hB8 : 8'h00;   // R5
        push(1, 3'd4, 3'd4, by, 1'b1, 5);
        for (int i = 0; i < nb; i++) begin
            for (int l = 0; l < 4; l++) by[l*8 +: 8] = mact[l] ? pat(i, l) : 8'h00;
            push(1, 3'd4, 3'd4, by, 1'b1, 5);
        end
        tg = lane_w[8] ? 9 : 6;       // R6
        push(int'(t[30:24]) + 2, 3'd4, 3'd5, '0, 1'b0, tg);
        if (lane_w[4]) begin           // R7
            push(int'(c[22:16]) + 9, 3'd4, 3'd0, '0, 1'b0, 7);
            mclk_on = 1;
        end else begin
            push(int'(c[14:8]) + 8,  3'd4, 3'd0, '0, 1'b0, tg);
            push(int'(k[30:24]) + 1, 3'd5, 3'd0, '0, 1'b0, tg);
            push(int'(c[22:16]) + 9, 3'd0, 3'd0, '0, 1'b0, tg);
            mclk_on = 0;
        end
    endtask

    always @(negedge clk) begin
        if (run && !fin) begin
            if (q.size() != 0) e = q[0];
            else e = '{mclk_on ? 3'd4 : 3'd0, 3'd0, 32'h0, 1'b0, 4'h0, 7};
            chk(clk_line == e.ck, e.tag, "clock line", int'(clk_line), int'(e.ck));
            chk(phy_ready == mready, 2, "ready", int'(phy_ready), int'(mready));   // R2
            chk(tx_ready == e.rdy, 5, "tx_ready", int'(tx_ready), int'(e.rdy));
            for (int l = 0; l < 4; l++) begin
                if (e.act[l]) begin
                    chk(dat_line[l*3 +: 3] == e.dl, e.tag, "data line", int'(dat_line[l*3 +: 3]), int'(e.dl));
                    chk(dat_byte[l*8 +: 8] == e.by[l*8 +: 8], 5, "data byte", int'(dat_byte[l*8 +: 8]), int'(e.by[l*8 +: 8]));
                end else begin   // R8 inactive lanes
                    chk(dat_line[l*3 +: 3] == 3'd0 && dat_byte[l*8 +: 8] == 8'h00, 8, "idle lane",
                        int'({dat_line[l*3 +: 3], dat_byte[l*8 +: 8]}), 0);
                end
            end
            // drive
            if (want && sent < nb) begin
                req_r = 1'b1;
                for (int l = 0; l < 4; l++) data_r[l*8 +: 8] = pat(sent, l);
                if (tx_ready) sent++;
            end else begin
                req_r = 1'b0;
            end
            // advance the model to the next cycle
            was_idle = (q.size() == 0);
            go = was_idle && mready && req_r && !reload_r;
            if (!was_idle) void'(q.pop_front());
            if (!mready) begin
                if (mw == int'(wake_w)) mready = 1;
                else mw++;
            end
            if (was_idle && reload_r) begin
                mready = 0;
                mw = 0;
            end
            if (go) push_burst();
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic burst(int n);
        nb = n;
        sent = 0;
        want = 1;
        do @(posedge clk); while (!(sent >= nb && q.size() == 0));
        #1;
        want = 0;
    endtask

    task automatic summary();
        fin = 1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !fin) begin
            nerr++;
            $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cyc);
            summary();
        end
    end

    initial begin
        ctl_w = 32'h0000_0114;   // pre 20, post 1, gap 0
        clk_w = 32'h0205_0001;   // lpx 1, prep 0, zero 5, trail 2
        dat_w = 32'h0002_0101;   // lpx 1, prep 1, zero 2, trail 0
        tick(3);
        // R1: reset state
        @(negedge clk);
        chk(clk_line == 3'd0 && dat_line == '0 && dat_byte == '0, 1, "lines in reset",
            int'(clk_line), 0);
        chk(!phy_ready && !tx_ready, 1, "flags in reset", int'({phy_ready, tx_ready}), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        run = 1;
        // R2: request raised before ready is held off
        burst(3);
        lane_w = 9'h001;          // R8: two lanes
        burst(1);
        lane_w = 9'h003;
        ctl_w = 32'h0000_0103;    // R3: clock-pre floor
        burst(2);
        ctl_w = 32'h0000_0114;
        lane_w = 9'h013;          // R7: continuous clock
        burst(2);
        tick(5);
        burst(3);
        lane_w = 9'h003;          // leave continuous mode
        burst(1);
        tick(3);
        lane_w = 9'h103;          // R9: defaults
        burst(2);
        lane_w = 9'h003;
        reload_r = 1'b1;          // R2: reload restarts wakeup
        tick(1);
        reload_r = 1'b0;
        burst(2);
        lane_w = 9'h000;          // R8: one lane
        burst(4);
        tick(4);
        summary();
    end

endmodule